// File: doc/BRIEF.md
# Programmable-Threshold FIFO with Fall-Through Option

This block is a first-in first-out queue controller built around an inferred two-port storage array. Its write side and its read side have the same data width. It keeps one write pointer and one read pointer, and from their distance it derives four status flags: full, empty, almost full and almost empty. The two "almost" levels come from input ports, so they can be changed while the queue is running.

A parameter selects the clocking. The queue can run on one shared clock. It can also run with an unrelated write clock and read clock. In the two-clock build, each pointer crosses to the other side in reflected binary (Gray) form through a chain of synchronizer flops. Each side therefore works from a slightly old view of the other pointer. The write side computes full and almost full, and the read side computes empty and almost empty. Both pairs err on the safe side.

A mode input selects how read data is presented:
- In standard mode, a read request returns the oldest word on the following read clock edge.
- In fall-through mode, the oldest word is shown on the output before anyone asks for it, and empty is low only while that word is valid. A read request then consumes the shown word and brings up the next one.

Top module: `fifo_fwft_ctrl`

## Requirements
- R1: While reset is held and after it is released with no traffic, empty=1, full=0, almost_empty=1 and rd_data=0. almost_full is 1 only when afull_level is 0.
- R2: In standard mode (fwft_mode=0), a read edge with rd_en=1 while empty=0 places the oldest stored word on rd_data after that edge. Words leave in the order they were written.
- R3: In fall-through mode (fwft_mode=1), a word written into an empty queue appears on rd_data with empty=0 and no read request. On one clock, this happens two edges after the edge that wrote it (one edge to store it, one to load it).
- R4: In fall-through mode, a read edge with rd_en=1 while empty=0 consumes the shown word. On the same edge the next stored word, if there is one, is loaded. Otherwise empty returns to 1.
- R5: A write request while full=1 is dropped: no pointer moves and the stored words are read back unchanged. On one clock, a read on that same edge does not allow the write.
- R6: In standard mode, a read request while empty=1 is dropped: rd_data and all flags are unchanged.
- R7: full=1 exactly when the storage array holds 2^ADDR_W words, as seen from the write side. In fall-through mode, the output register holds one more word.
- R8: almost_full=1 exactly when the write-side count of words in the storage array is at least afull_level.
- R9: almost_empty=1 exactly when the read-side count is at most aempty_level. In fall-through mode, this count includes a valid word held in the output register.
- R10: In the two-clock build, each pointer changes by at most one Gray bit per edge of its own clock. Words cross unrelated clocks in order, with none lost or repeated, while the writer obeys full and the reader obeys empty.
- R11: With rd_en=0 and empty=0, rd_data holds its value across a read clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock; also the only clock when DUAL_CLOCK=0 |
| rd_clk | input | 1 | Read clock; used only when DUAL_CLOCK=1 |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| fwft_mode | input | 1 | 1 = fall-through presentation, 0 = standard; change only while reset is held |
| afull_level | input | ADDR_W+1 | Almost-full threshold |
| aempty_level | input | ADDR_W+1 | Almost-empty threshold |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read word |
| full | output | 1 | Storage array full (write side) |
| almost_full | output | 1 | Write-side count at or above afull_level |
| empty | output | 1 | No word available to the reader |
| almost_empty | output | 1 | Read-side count at or below aempty_level |

## Verification
The two functions that can fall on the same edge are a write and a read. The sharpest cases are a read that frees a slot on the edge where a write meets full, and a fall-through reload on the edge where the shown word is consumed while a new word is being written. The sweeps drive both enables with pseudo-random bias on every edge, with the bias leaning towards filling on some runs and towards draining on others. This keeps the queue hitting both boundaries in both modes and at every threshold. A queue model in the bench predicts every flag and the read word, and each output is judged against that prediction at mid-cycle.

// File: rtl/fifo_fwft_ctrl.sv
module fifo_fwft_ctrl #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int DUAL_CLOCK  = 0,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic [ADDR_W:0]   afull_level,
  input  logic [ADDR_W:0]   aempty_level,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              almost_full,
  output logic              empty,
  output logic              almost_empty
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PW    = ADDR_W + 1;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic              rclk;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wptr, rptr, rptr_at_w, wptr_at_r;
  logic [PW-1:0]     wcount, mcount;
  logic [PW:0]       rcount;
  logic              ovalid, mem_empty, wr_ok, std_rd, fwft_load, pop;

  assign rclk = (DUAL_CLOCK != 0) ? rd_clk : wr_clk;

  // write side
  assign wcount      = wptr - rptr_at_w;
  assign full        = (wcount == PW'(DEPTH));
  assign almost_full = (wcount >= afull_level);
  assign wr_ok       = wr_en && !full;

  always_ff @(posedge wr_clk or negedge rst_n)
    if (!rst_n) wptr <= '0;
    else if (wr_ok) wptr <= wptr + 1'b1;

  always_ff @(posedge wr_clk)
    if (wr_ok) mem[wptr[ADDR_W-1:0]] <= wr_data;

  // read side
  assign mcount    = wptr_at_r - rptr;
  assign mem_empty = (mcount == '0);
  assign std_rd    = !fwft_mode && rd_en && !mem_empty;
  assign fwft_load = fwft_mode && !mem_empty && (!ovalid || rd_en);
  assign pop       = std_rd || fwft_load;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rptr    <= '0;
      rd_data <= '0;
    end else if (pop) begin
      rptr    <= rptr + 1'b1;
      rd_data <= mem[rptr[ADDR_W-1:0]];
    end

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n)          ovalid <= 1'b0;
    else if (!fwft_mode) ovalid <= 1'b0;
    else if (fwft_load)  ovalid <= 1'b1;
    else if (rd_en)      ovalid <= 1'b0;

  assign empty        = fwft_mode ? !ovalid : mem_empty;
  assign rcount       = {1'b0, mcount} + (PW+1)'(fwft_mode && ovalid);
  assign almost_empty = (rcount <= {1'b0, aempty_level});

  generate
    if (DUAL_CLOCK != 0) begin : g_async
      logic [PW-1:0] wptr_g, rptr_g;
      logic [PW-1:0] r2w [SYNC_STAGES];
      logic [PW-1:0] w2r [SYNC_STAGES];

      always_ff @(posedge wr_clk or negedge rst_n)
        if (!rst_n)     wptr_g <= '0;
        else if (wr_ok) wptr_g <= to_gray(wptr + 1'b1);

      always_ff @(posedge rclk or negedge rst_n)
        if (!rst_n)   rptr_g <= '0;
        else if (pop) rptr_g <= to_gray(rptr + 1'b1);

      always_ff @(posedge wr_clk or negedge rst_n)
        if (!rst_n) begin
          for (int i = 0; i < SYNC_STAGES; i++) r2w[i] <= '0;
        end else begin
          r2w[0] <= rptr_g;
          for (int i = 1; i < SYNC_STAGES; i++) r2w[i] <= r2w[i-1];
        end

      always_ff @(posedge rclk or negedge rst_n)
        if (!rst_n) begin
          for (int i = 0; i < SYNC_STAGES; i++) w2r[i] <= '0;
        end else begin
          w2r[0] <= wptr_g;
          for (int i = 1; i < SYNC_STAGES; i++) w2r[i] <= w2r[i-1];
        end

      assign rptr_at_w = from_gray(r2w[SYNC_STAGES-1]);
      assign wptr_at_r = from_gray(w2r[SYNC_STAGES-1]);

      AST_WGRAY_ONE_BIT: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wptr_g ^ $past(wptr_g)) <= 1); // R10
      AST_RGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rptr_g ^ $past(rptr_g)) <= 1); // R10
    end else begin : g_sync
      assign rptr_at_w = rptr;
      assign wptr_at_r = wptr;

      AST_NOT_FULL_AND_EMPTY: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(full && empty)); // R7
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_en && full) |=> $stable(wptr)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft_mode && rd_en && empty) |=> $stable(rptr)); // R6
  AST_HOLD_DATA: assert property (@(posedge rclk) disable iff (!rst_n)
    (!rd_en && !empty) |=> $stable(rd_data)); // R11
  AST_FULL_IMPLIES_AF: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (full && afull_level <= PW'(DEPTH)) |-> almost_full); // R8
endmodule

// File: tb/fifo_fwft_ctrl_test.sv
module fifo_fwft_ctrl_test;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rclk = 1'b0;
  always #10 clk = ~clk;
  always #17 rclk = ~rclk;

  logic rst_n, mode, wr_en, rd_en;
  logic [AW:0] afl, ael;
  logic [7:0] wr_data, rd_data;
  logic full, af, empty, ae;

  fifo_fwft_ctrl #(.DATA_W(8), .ADDR_W(AW), .DUAL_CLOCK(0)) uut (
    .wr_clk(clk), .rd_clk(rclk), .rst_n(rst_n), .fwft_mode(mode),
    .afull_level(afl), .aempty_level(ael), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .full(full), .almost_full(af),
    .empty(empty), .almost_empty(ae));

  logic dc_we, dc_re;
  logic [7:0] dc_wd, dc_rd;
  logic dc_full, dc_af, dc_empty, dc_ae;

  fifo_fwft_ctrl #(.DATA_W(8), .ADDR_W(AW), .DUAL_CLOCK(1)) uut_dc (
    .wr_clk(clk), .rd_clk(rclk), .rst_n(rst_n), .fwft_mode(1'b1),
    .afull_level(4'd6), .aempty_level(4'd1), .wr_en(dc_we), .wr_data(dc_wd),
    .rd_en(dc_re), .rd_data(dc_rd), .full(dc_full), .almost_full(dc_af),
    .empty(dc_empty), .almost_empty(dc_ae));

  int total = 0, bad = 0;
  bit done = 0;
  int q[$];
  bit ov;
  int mdout;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int mc = q.size();
    check("R7 full", full, mc == DEPTH);
    check(mode ? "R3 empty" : "R6 empty", empty, mode ? !ov : (mc == 0));
    check("R8 almost_full", af, mc >= afl);
    check("R9 almost_empty", ae, (mc + int'(mode && ov)) <= ael);
    check(mode ? "R4 rd_data" : "R2 rd_data", rd_data, mdout);
  endtask

  task automatic cycle(input bit we, input bit re, input logic [7:0] wd);
    int mc;
    @(negedge clk);
    compare_all();
    wr_en = we; rd_en = re; wr_data = wd;
    mc = q.size();
    if (!mode) begin
      if (re && mc > 0) mdout = q.pop_front();
    end else if (mc > 0 && (!ov || re)) begin
      mdout = q.pop_front(); ov = 1;
    end else if (re) ov = 0;
    if (we && mc < DEPTH) q.push_back(wd);
  endtask

  task automatic do_reset(input bit m, input int a_f, input int a_e);
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0; wr_data = 0;
    mode = m; afl = (AW+1)'(a_f); ael = (AW+1)'(a_e);
    q.delete(); ov = 0; mdout = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    dc_we = 0; dc_re = 0; dc_wd = 0;
    // R1 reset state
    do_reset(0, 3, 2);
    check("R1 empty", empty, 1); check("R1 full", full, 0);
    check("R1 almost_empty", ae, 1); check("R1 almost_full", af, 0);
    check("R1 rd_data", rd_data, 0);
    do_reset(1, 0, 0);
    check("R1 almost_full at level 0", af, 1);

    // R3 / R4 directed fall-through
    do_reset(1, 4, 2);
    cycle(1, 0, 8'h5A);
    cycle(0, 0, 0);
    check("R3 empty before load", empty, 1);
    cycle(0, 0, 0);
    check("R3 shown without read", empty, 0);
    check("R3 shown word", rd_data, 8'h5A);
    cycle(0, 1, 0);
    cycle(0, 0, 0);
    check("R4 consumed -> empty", empty, 1);

    // R5 / R6 / R11 directed standard
    do_reset(0, DEPTH, 0);
    for (int i = 0; i < DEPTH + 2; i++) cycle(1, 0, 8'(100 + i));
    cycle(0, 0, 0);
    check("R7 full after fill", full, 1);
    for (int i = 0; i < DEPTH; i++) begin
      cycle(0, 1, 0);
      cycle(0, 0, 0);
      check("R5 content intact", rd_data, 100 + i);
      cycle(0, 0, 0);
      check("R11 held", rd_data, 100 + i);
    end
    cycle(0, 1, 0);
    cycle(0, 0, 0);
    check("R6 read on empty keeps data", rd_data, 100 + DEPTH - 1);
    check("R6 still empty", empty, 1);

    // sweeps over mode and thresholds
    for (int m = 0; m < 2; m++)
      for (int thr = 0; thr <= DEPTH; thr++) begin
        do_reset(m[0], thr, DEPTH - thr);
        for (int c = 0; c < 220; c++) begin
          bit we, re;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          case (thr % 3)
            0: begin we = lfsr[1:0] != 0; re = lfsr[3:2] == 0; end
            1: begin we = lfsr[1:0] == 0; re = lfsr[3:2] != 0; end
            default: begin we = lfsr[1]; re = lfsr[4]; end
          endcase
          if (c < 12) begin we = 1; re = 0; end
          cycle(we, re, lfsr[11:4]);
        end
        cycle(0, 0, 0);
      end

    // R10 two-clock transfer
    do_reset(1, 4, 2);
    begin
      bit saw_full = 0;
      fork
        begin
          int k = 0;
          while (k < 40) begin
            @(negedge clk);
            if (dc_full) saw_full = 1;
            if (!dc_full) begin dc_we = 1; dc_wd = 8'(k * 7 + 3); k++; end
            else dc_we = 0;
          end
          @(negedge clk); dc_we = 0;
        end
        begin
          int idx = 0;
          while (idx < 40) begin
            @(negedge rclk);
            if (!dc_empty) begin
              check("R10 order across clocks", dc_rd, (idx * 7 + 3) % 256);
              idx++; dc_re = 1;
            end else dc_re = 0;
          end
          @(negedge rclk); dc_re = 0;
        end
      join
      check("R10 writer met full", saw_full, 1);
      repeat (10) @(negedge rclk);
      check("R10 drained empty", dc_empty, 1);
      check("R10 drained almost_empty", dc_ae, 1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule